// File: doc/BRIEF.md
# SD Command Response Capture Unit

This block sits between a host register interface and the card-side command engine of an SD/MMC host controller. The host writes a 32-bit command argument as two 16-bit halves and then a 16-bit command word. The unit decodes that word and issues a command request to the card side, carrying the index, argument, direction, command type and a busy-response flag. It then waits for the card's response: up to 16 bytes, plus a byte count.

When the response arrives, the unit checks its length against the expected response type and flags a timeout when it is too short. It tests the card-status word for error bits. It updates a 16-bit status register whose completion bits depend on the response type and the command index. It also stores the response bytes into eight 16-bit response halfwords.

An initialization-only command with index 0 never reaches the card and completes at once. The host clears status bits by writing ones.

Top module: `sd_rsp_capture`

## Requirements
- R1: An accepted command write (enable high, no response pending) raises `card_req_o` for exactly one cycle, starting the cycle after the write. `card_idx_o` then shows word bits 5:0, `card_ctype_o` bits 13:12 and `card_dir_o` bit 15. `card_arg_o` shows the argument, whose low half and high half are each written separately and change only their own 16 bits.
- R2: A command write has no effect on status, responses or the card request while enable is low, or while an earlier command is still waiting for its response.
- R3: An accepted command write zeroes all eight response halfwords in the cycle after the write.
- R4: If word bit 7 (init) is set and the index is 0, status bit 0 is set in the cycle after the write. No other status bit changes and no card request is issued.
- R5: `card_r1b_o` is high for a command whose response type (bits 10:8) is 1 and whose busy flag (bit 11) is set. It is low for every other command.
- R6: Response type codes are 0 none, 1 R1, 2 R2, 3 R3 and 6 R6. R1, R3 and R6 need at least 4 bytes and R2 needs 16. A shorter response sets status bit 7 instead of the completion bits. Other type codes have no length check and no error test.
- R7: For R1, the status word is formed from bytes 0..3, with byte 0 most significant. Any set bit in {31:26, 24:19, 16} sets status bit 14. Bit 3 joins this set while `ake_chk_i` is high.
- R8: For R6, only the low 16 bits of that word are tested, against bits 15:13 and bit 3. A hit sets status bit 14.
- R9: For R3 with enough bytes, word bit 31 set clears every status bit except 15:13. Word bit 31 clear sets status bit 12.
- R10: When no error hit occurs, every status bit except 15, 13 and 12 is cleared before the completion bits are set. This includes a timeout.
- R11: Response halfword 7−k receives byte 2k as its high byte and byte 2k+1 as its low byte. Bytes are stored unless the type is none, a timeout occurred, or an untyped response has length 0. In those cases the halfwords stay zero.
- R12: On a response without timeout, index 12 sets status bits 0 and 2. Any other index sets only bit 0.
- R13: After reset, status, responses and request are zero. Writing ones to the status-clear port clears the matching status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Controller enable; command writes are dropped while low |
| ake_chk_i | input | 1 | Adds the authentication-sequence error bit to the R1 error test |
| arg_lo_we_i | input | 1 | Write strobe for argument bits 15:0 |
| arg_hi_we_i | input | 1 | Write strobe for argument bits 31:16 |
| arg_wdata_i | input | 16 | Argument half written by either strobe |
| cmd_we_i | input | 1 | Command word write strobe |
| cmd_word_i | input | 16 | Command word |
| stat_clr_we_i | input | 1 | Status clear strobe |
| stat_clr_i | input | 16 | Status bits to clear (ones clear) |
| card_req_o | output | 1 | One-cycle command request to the card side |
| card_idx_o | output | 6 | Command index |
| card_arg_o | output | 32 | Command argument |
| card_dir_o | output | 1 | Data direction of the command |
| card_ctype_o | output | 2 | Command type field |
| card_r1b_o | output | 1 | Response expected with busy |
| card_rsp_valid_i | input | 1 | Card response available this cycle |
| card_rsp_len_i | input | 5 | Number of response bytes (0 to 16) |
| card_rsp_data_i | input | 128 | Response bytes, byte k in bits 8k+7:8k |
| status_o | output | 16 | Status register |
| rsp_o | output | 128 | Response halfwords, halfword j in bits 16j+15:16j |

## Verification
Assertions watch every cycle for the following:
- the request stays a single-cycle pulse;
- dropped command writes leave status and responses untouched;
- accepted writes clear the response halfwords;
- the init-only command completes without a request;
- a short R2 answer raises the timeout bit;
- a stop command with no response sets both completion bits.

The interplay of the status bits can only be shown by the bench's scenarios against its own model. This covers the R3 clearing, the no-error clearing, and the error tests with and without the authentication bit. The same applies to the byte order of the stored halfwords and to how status accumulates across command sequences with interleaved clears.

// File: rtl/sd_rsp_pkg.sv
package sd_rsp_pkg;
   localparam int IDX_W     = 6;
   localparam int ARG_W     = 32;
   localparam int STAT_W    = 16;
   localparam int RSP_BYTES = 16;
   localparam int HW_W      = 16;
   localparam int NUM_HW    = RSP_BYTES * 8 / HW_W;
   localparam int LEN_W     = $clog2(RSP_BYTES + 1);

   localparam logic [2:0] RT_NONE = 3'd0;
   localparam logic [2:0] RT_R1   = 3'd1;
   localparam logic [2:0] RT_R2   = 3'd2;
   localparam logic [2:0] RT_R3   = 3'd3;
   localparam logic [2:0] RT_R6   = 3'd6;

   localparam int ST_EOC  = 0;
   localparam int ST_STOP = 2;
   localparam int ST_CTO  = 7;
   localparam int ST_OCR  = 12;
   localparam int ST_CERR = 14;

   typedef struct packed {
      logic             dir;
      logic [1:0]       ctype;
      logic             busy;
      logic [2:0]       rtype;
      logic             init;
      logic [IDX_W-1:0] idx;
   } cmd_t;
endpackage

// File: rtl/sd_cmd_decode.sv
module sd_cmd_decode
   import sd_rsp_pkg::*;
(
   input  logic [15:0] word_i,
   output cmd_t        cmd_o,
   output logic        r1b_o
);
   always_comb begin
      cmd_o.dir   = word_i[15];
      cmd_o.ctype = word_i[13:12];
      cmd_o.busy  = word_i[11];
      cmd_o.rtype = word_i[10:8];
      cmd_o.init  = word_i[7];
      cmd_o.idx   = word_i[IDX_W-1:0];
   end
   // busy flag promotes a plain R1 to the busy variant
   assign r1b_o = (cmd_o.rtype == RT_R1) && cmd_o.busy;
endmodule

// File: rtl/sd_rsp_eval.sv
module sd_rsp_eval
   import sd_rsp_pkg::*;
#(
   parameter logic [31:0]       ERR_MASK  = 32'hFDF9_0000,
   parameter int                AKE_BIT   = 3,
   parameter logic [15:0]       R6_MASK   = 16'hE000,
   parameter logic [15:0]       KEEP_MASK = 16'hB000,
   parameter logic [15:0]       OCR_KEEP  = 16'hE000,
   parameter logic [IDX_W-1:0]  STOP_IDX  = 6'd12
) (
   input  cmd_t              cmd_i,
   input  logic [LEN_W-1:0]  len_i,
   input  logic [31:0]       head_i,
   input  logic [STAT_W-1:0] base_i,
   input  logic              ake_i,
   output logic [STAT_W-1:0] nxt_o,
   output logic              store_o
);
   localparam logic [31:0] AKE_MASK = 32'd1 << AKE_BIT;
   localparam logic [15:0] R6_FULL  = R6_MASK | AKE_MASK[15:0];

   logic [31:0] word;
   logic [31:0] r1_mask;
   logic        to, err;

   assign word    = {head_i[7:0], head_i[15:8], head_i[23:16], head_i[31:24]};
   assign r1_mask = ERR_MASK | (ake_i ? AKE_MASK : 32'd0);

   always_comb begin
      nxt_o   = base_i;
      to      = 1'b0;
      err     = 1'b0;
      store_o = 1'b0;
      case (cmd_i.rtype)
         RT_NONE: store_o = 1'b0;
         RT_R1: begin
            if (len_i < LEN_W'(4)) to = 1'b1;
            else begin
               err     = |(word & r1_mask);
               store_o = 1'b1;
            end
         end
         RT_R2: begin
            if (len_i < LEN_W'(16)) to = 1'b1;
            else store_o = 1'b1;
         end
         RT_R3: begin
            if (len_i < LEN_W'(4)) to = 1'b1;
            else begin
               store_o = 1'b1;
               if (word[31]) nxt_o = nxt_o & OCR_KEEP;
               else          nxt_o[ST_OCR] = 1'b1;
            end
         end
         RT_R6: begin
            if (len_i < LEN_W'(4)) to = 1'b1;
            else begin
               err     = |(word[15:0] & R6_FULL);
               store_o = 1'b1;
            end
         end
         default: store_o = (len_i != '0);
      endcase
      if (err) nxt_o[ST_CERR] = 1'b1;
      else     nxt_o = nxt_o & KEEP_MASK;
      if (to) nxt_o[ST_CTO] = 1'b1;
      else begin
         nxt_o[ST_EOC] = 1'b1;
         if (cmd_i.idx == STOP_IDX) nxt_o[ST_STOP] = 1'b1;
      end
   end
endmodule

// File: rtl/sd_rsp_pack.sv
module sd_rsp_pack
   import sd_rsp_pkg::*;
(
   input  logic [RSP_BYTES*8-1:0] bytes_i,
   output logic [NUM_HW*HW_W-1:0] hw_o
);
   for (genvar k = 0; k < NUM_HW; k++) begin : g_hw
      // halfword (NUM_HW-1-k) takes bytes 2k (high) and 2k+1 (low)
      assign hw_o[HW_W*(NUM_HW-1-k) +: HW_W] =
         {bytes_i[8*(2*k) +: 8], bytes_i[8*(2*k+1) +: 8]};
   end
endmodule

// File: rtl/sd_rsp_capture.sv
module sd_rsp_capture
   import sd_rsp_pkg::*;
#(
   parameter logic [31:0]      ERR_MASK = 32'hFDF9_0000,
   parameter int               AKE_BIT  = 3,
   parameter logic [15:0]      R6_MASK  = 16'hE000,
   parameter logic [IDX_W-1:0] STOP_IDX = 6'd12
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      en_i,
   input  logic                      ake_chk_i,
   input  logic                      arg_lo_we_i,
   input  logic                      arg_hi_we_i,
   input  logic [15:0]               arg_wdata_i,
   input  logic                      cmd_we_i,
   input  logic [15:0]               cmd_word_i,
   input  logic                      stat_clr_we_i,
   input  logic [15:0]               stat_clr_i,
   output logic                      card_req_o,
   output logic [5:0]                card_idx_o,
   output logic [31:0]               card_arg_o,
   output logic                      card_dir_o,
   output logic [1:0]                card_ctype_o,
   output logic                      card_r1b_o,
   input  logic                      card_rsp_valid_i,
   input  logic [4:0]                card_rsp_len_i,
   input  logic [127:0]              card_rsp_data_i,
   output logic [15:0]               status_o,
   output logic [127:0]              rsp_o
);
   if (AKE_BIT < 0 || AKE_BIT > 15) begin : g_bad_ake
      $error("AKE_BIT must address the low status halfword");
   end
   if (NUM_HW * HW_W != RSP_BYTES * 8) begin : g_bad_geom
      $error("response geometry mismatch");
   end

   cmd_t                  dec, cmd_q;
   logic                  dec_r1b, r1b_q;
   logic                  waiting, req_q;
   logic [ARG_W-1:0]      arg_q;
   logic [STAT_W-1:0]     status_q, stat_base, eval_nxt;
   logic [NUM_HW*HW_W-1:0] rsp_q, packed_hw;
   logic                  store, accept, init0;

   sd_cmd_decode u_dec (
      .word_i (cmd_word_i),
      .cmd_o  (dec),
      .r1b_o  (dec_r1b)
   );

   sd_rsp_eval #(
      .ERR_MASK (ERR_MASK),
      .AKE_BIT  (AKE_BIT),
      .R6_MASK  (R6_MASK),
      .STOP_IDX (STOP_IDX)
   ) u_eval (
      .cmd_i   (cmd_q),
      .len_i   (card_rsp_len_i),
      .head_i  (card_rsp_data_i[31:0]),
      .base_i  (stat_base),
      .ake_i   (ake_chk_i),
      .nxt_o   (eval_nxt),
      .store_o (store)
   );

   sd_rsp_pack u_pack (
      .bytes_i (card_rsp_data_i),
      .hw_o    (packed_hw)
   );

   assign stat_base = stat_clr_we_i ? (status_q & ~stat_clr_i) : status_q;
   assign accept    = en_i && cmd_we_i && !waiting;
   assign init0     = dec.init && (dec.idx == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         waiting  <= 1'b0;
         req_q    <= 1'b0;
         r1b_q    <= 1'b0;
         cmd_q    <= '0;
         arg_q    <= '0;
         status_q <= '0;
         rsp_q    <= '0;
      end else begin
         req_q <= 1'b0;
         if (arg_lo_we_i) arg_q[15:0]  <= arg_wdata_i;
         if (arg_hi_we_i) arg_q[31:16] <= arg_wdata_i;
         if (accept) begin
            rsp_q <= '0;
            cmd_q <= dec;
            r1b_q <= dec_r1b;
            if (init0) begin
               status_q <= stat_base | STAT_W'(1 << ST_EOC);
            end else begin
               status_q <= stat_base;
               waiting  <= 1'b1;
               req_q    <= 1'b1;
            end
         end else if (waiting && card_rsp_valid_i) begin
            waiting  <= 1'b0;
            status_q <= eval_nxt;
            if (store) rsp_q <= packed_hw;
         end else begin
            status_q <= stat_base;
         end
      end
   end

   assign card_req_o   = req_q;
   assign card_idx_o   = cmd_q.idx;
   assign card_dir_o   = cmd_q.dir;
   assign card_ctype_o = cmd_q.ctype;
   assign card_r1b_o   = r1b_q;
   assign card_arg_o   = arg_q;
   assign status_o     = status_q;
   assign rsp_o        = rsp_q;

   // R1: request is a single-cycle pulse
   assert_req_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
      card_req_o |=> !card_req_o);

   // R2: dropped write while disabled changes nothing
   assert_ignore_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_i && cmd_we_i && !waiting && !stat_clr_we_i)
      |=> (!card_req_o && $stable(status_o) && $stable(rsp_o)));

   // R3: accepted write clears the response halfwords
   assert_rsp_zeroed_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && cmd_we_i && !waiting) |=> (rsp_o == '0));

   // R4: init-only index 0 completes without a card request
   assert_init_no_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && cmd_we_i && !waiting && cmd_word_i[7] && cmd_word_i[5:0] == 6'd0)
      |=> (!card_req_o && status_o[ST_EOC]));

   // R6: short R2 answer flags timeout
   assert_r2_short_timeout_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (waiting && card_rsp_valid_i && cmd_q.rtype == RT_R2 && card_rsp_len_i < 5'd16)
      |=> status_o[ST_CTO]);

   // R12: stop command with no response sets both completion bits
   assert_stop_bits_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (waiting && card_rsp_valid_i && cmd_q.rtype == RT_NONE && cmd_q.idx == STOP_IDX)
      |=> (status_o[ST_EOC] && status_o[ST_STOP]));
endmodule

// File: tb/tb_sd_rsp_capture.sv
`timescale 1ns/1ps
module tb_sd_rsp_capture;
   logic         clk = 1'b0;
   logic         rst_n;
   logic         en_i, ake_chk_i, arg_lo_we_i, arg_hi_we_i, cmd_we_i, stat_clr_we_i;
   logic [15:0]  arg_wdata_i, cmd_word_i, stat_clr_i;
   logic         card_req_o, card_dir_o, card_r1b_o, card_rsp_valid_i;
   logic [5:0]   card_idx_o;
   logic [31:0]  card_arg_o;
   logic [1:0]   card_ctype_o;
   logic [4:0]   card_rsp_len_i;
   logic [127:0] card_rsp_data_i, rsp_o;
   logic [15:0]  status_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [15:0]  m_stat;
   logic [127:0] m_rsp;
   logic [31:0]  m_arg;

   always #5 clk = ~clk;

   sd_rsp_capture dut (.*);

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_stat(input logic [15:0] s, input logic [15:0] w,
         input logic [4:0] len, input logic [127:0] d, input bit ake);
      logic [31:0] cs = {d[7:0], d[15:8], d[23:16], d[31:24]};
      logic [31:0] m1 = 32'hFDF9_0000 | (ake ? 32'h8 : 32'h0);
      logic [15:0] n = s;
      bit to = 0;
      bit err = 0;
      case (w[10:8])
         3'd1: if (len < 4) to = 1; else err = |(cs & m1);
         3'd2: if (len < 16) to = 1;
         3'd3: if (len < 4) to = 1; else if (cs[31]) n = n & 16'hE000; else n = n | 16'h1000;
         3'd6: if (len < 4) to = 1; else err = |(cs[15:0] & 16'hE008);
         default: ;
      endcase
      n = err ? (n | 16'h4000) : (n & 16'hB000);
      if (to) n = n | 16'h0080;
      else if (w[5:0] == 6'd12) n = n | 16'h0005;
      else n = n | 16'h0001;
      return n;
   endfunction

   function automatic logic [127:0] exp_rsp(input logic [15:0] w, input logic [4:0] len,
                                            input logic [127:0] d);
      logic [127:0] r = '0;
      bit st;
      case (w[10:8])
         3'd0: st = 0;
         3'd2: st = (len >= 16);
         3'd1, 3'd3, 3'd6: st = (len >= 4);
         default: st = (len != 0);
      endcase
      if (st)
         for (int k = 0; k < 8; k++)
            r[16*(7-k) +: 16] = {d[8*(2*k) +: 8], d[8*(2*k+1) +: 8]};
      return r;
   endfunction

   task automatic write_arg(input bit hi, input logic [15:0] v);
      @(negedge clk);
      arg_wdata_i = v;
      if (hi) arg_hi_we_i = 1; else arg_lo_we_i = 1;
      @(negedge clk);
      arg_hi_we_i = 0; arg_lo_we_i = 0;
      if (hi) m_arg[31:16] = v; else m_arg[15:0] = v;
   endtask

   task automatic clear_stat(input logic [15:0] v);
      @(negedge clk);
      stat_clr_we_i = 1; stat_clr_i = v;
      @(negedge clk);
      stat_clr_we_i = 0;
      m_stat = m_stat & ~v;
      chk(status_o == m_stat, "R13", "status after clear", status_o, m_stat);
   endtask

   task automatic run_cmd(input logic [15:0] w, input logic [4:0] len,
                          input logic [127:0] d, input string tag);
      bit init0 = w[7] && (w[5:0] == 6'd0);
      logic [15:0] es;
      @(negedge clk);
      cmd_we_i = 1; cmd_word_i = w;
      @(negedge clk);
      cmd_we_i = 0;
      if (!en_i) begin
         chk(card_req_o == 0, "R2", "req while disabled", card_req_o, 0);
         chk(status_o == m_stat, "R2", "status while disabled", status_o, m_stat);
         chk(rsp_o == m_rsp, "R2", "rsp while disabled", rsp_o, m_rsp);
         return;
      end
      m_rsp = '0;
      chk(rsp_o == 0, "R3", "rsp zeroed", rsp_o, 0);
      if (init0) begin
         m_stat = m_stat | 16'h1;
         chk(card_req_o == 0, "R4", "no req on init0", card_req_o, 0);
         chk(status_o == m_stat, "R4", "status init0", status_o, m_stat);
         return;
      end
      chk(card_req_o == 1, "R1", "req raised", card_req_o, 1);
      chk(card_idx_o == w[5:0], "R1", "index", card_idx_o, w[5:0]);
      chk(card_arg_o == m_arg, "R1", "argument", card_arg_o, m_arg);
      chk({card_dir_o, card_ctype_o} == {w[15], w[13:12]}, "R1", "dir/ctype",
          {card_dir_o, card_ctype_o}, {w[15], w[13:12]});
      chk(card_r1b_o == (w[10:8] == 3'd1 && w[11]), "R5", "r1b flag",
          card_r1b_o, (w[10:8] == 3'd1 && w[11]));
      card_rsp_valid_i = 1; card_rsp_len_i = len; card_rsp_data_i = d;
      @(negedge clk);
      card_rsp_valid_i = 0;
      chk(card_req_o == 0, "R1", "req pulse ended", card_req_o, 0);
      es = exp_stat(m_stat, w, len, d, ake_chk_i);
      m_stat = es;
      m_rsp = exp_rsp(w, len, d);
      chk(status_o == es, tag, "status after response", status_o, es);
      chk(rsp_o == m_rsp, "R11", "response halfwords", rsp_o, m_rsp);
   endtask

   function automatic logic [127:0] rnd128();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [127:0] d;
      void'($urandom(32'd2024));
      rst_n = 0; en_i = 0; ake_chk_i = 0; arg_lo_we_i = 0; arg_hi_we_i = 0;
      cmd_we_i = 0; stat_clr_we_i = 0; arg_wdata_i = 0; cmd_word_i = 0;
      stat_clr_i = 0; card_rsp_valid_i = 0; card_rsp_len_i = 0; card_rsp_data_i = 0;
      m_stat = 0; m_rsp = 0; m_arg = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R13 reset state
      chk(status_o == 0, "R13", "reset status", status_o, 0);
      chk(rsp_o == 0, "R13", "reset rsp", rsp_o, 0);
      chk(card_req_o == 0, "R13", "reset req", card_req_o, 0);

      // R2 disabled write
      run_cmd(16'h0111, 5'd16, rnd128(), "R2");
      en_i = 1;
      // R1 argument halves
      write_arg(0, 16'hBEEF);
      write_arg(1, 16'hDEAD);
      write_arg(0, 16'h1234);
      // R4 init command with index 0
      run_cmd(16'h0080, 5'd0, '0, "R4");
      clear_stat(16'hFFFF);
      // R5/R7 R1b with an error hit
      d = '0; d[7:0] = 8'h80;
      run_cmd(16'h0911, 5'd4, d, "R7");
      // R7 ake bit: card status bit 3 is byte 3 bit 3
      d = '0; d[31:24] = 8'h08;
      run_cmd(16'h0111, 5'd4, d, "R7");
      ake_chk_i = 1;
      run_cmd(16'h0111, 5'd4, d, "R7");
      ake_chk_i = 0;
      // R8 R6 with hit in bits 15:13 and no hit
      d = '0; d[23:16] = 8'h20;
      run_cmd(16'h0603, 5'd6, d, "R8");
      d = '0; d[23:16] = 8'h1F; d[31:24] = 8'hF7;
      run_cmd(16'h0603, 5'd6, d, "R10");
      // R9 R3 both polarities
      d = rnd128(); d[7] = 1'b0;
      run_cmd(16'h0329, 5'd6, d, "R9");
      d[7] = 1'b1;
      run_cmd(16'h0329, 5'd6, d, "R9");
      // R6 timeouts
      run_cmd(16'h0202, 5'd15, rnd128(), "R6");
      run_cmd(16'h0111, 5'd3, rnd128(), "R6");
      // R12 stop command and R11 untyped store
      run_cmd(16'h000C, 5'd0, rnd128(), "R12");
      run_cmd(16'h0405, 5'd1, rnd128(), "R11");
      run_cmd(16'h0505, 5'd0, rnd128(), "R11");
      // R2 write while waiting
      @(negedge clk); cmd_we_i = 1; cmd_word_i = 16'h0101;
      @(negedge clk); cmd_we_i = 0;
      m_rsp = '0;
      chk(card_req_o == 1, "R1", "req before busy write", card_req_o, 1);
      cmd_we_i = 1; cmd_word_i = 16'h0080;
      @(negedge clk); cmd_we_i = 0;
      chk(card_req_o == 0, "R2", "no req while waiting", card_req_o, 0);
      chk(status_o == m_stat, "R2", "status while waiting", status_o, m_stat);
      d = '0;
      card_rsp_valid_i = 1; card_rsp_len_i = 5'd4; card_rsp_data_i = d;
      @(negedge clk); card_rsp_valid_i = 0;
      m_stat = exp_stat(m_stat, 16'h0101, 5'd4, d, 0);
      chk(status_o == m_stat, "R2", "first cmd completes", status_o, m_stat);

      // random mix
      for (int i = 0; i < 80; i++) begin
         logic [15:0] w;
         logic [4:0]  len;
         logic [2:0]  types [6] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd6, 3'd4};
         logic [4:0]  lens  [6] = '{5'd0, 5'd3, 5'd4, 5'd15, 5'd16, 5'd8};
         w = $urandom;
         w[10:8] = types[$urandom % 6];
         w[6] = 1'b0;
         if ($urandom % 8 == 0) w[5:0] = 6'd12;
         len = lens[$urandom % 6];
         d = rnd128();
         if ($urandom % 2) begin
            d[7:0] = 8'h00; d[15:8] &= 8'h06; d[23:16] &= 8'h1F; d[31:24] &= 8'hF7;
         end
         ake_chk_i = $urandom % 2;
         en_i = ($urandom % 10) != 0;
         if ($urandom % 5 == 0) write_arg($urandom % 2, $urandom);
         if ($urandom % 6 == 0) clear_stat($urandom);
         run_cmd(w, len, d, "R10");
      end
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule